// File: doc/BRIEF.md
# Floppy Head Step Sequencer

This block moves a floppy drive's read/write head by a requested number of tracks. A host writes one command byte. The top bit picks the direction of travel and the low seven bits give the number of steps. The block then produces that many active-low step pulses on the drive's step line, and it sets the direction line before the first pulse.

Pulses are paced by a slow step-rate clock. That clock is a square-wave level made by an external divider. At most one step starts on each rising edge of that level, and the block finds the edge by comparing the level with a registered copy of itself. Every step pulse is held low for a fixed number of system clocks.

When the head travels toward track zero and the drive reports that the head is at track zero, the seek ends early. A sticky status flag then records that track zero was reached. While a seek is running, a busy output stays high, and any further command write is ignored.

Top module: `head_step_seq`

## Requirements
- R1: After synchronous reset, `step_n` is 1, `busy` is 0 and `trk0_hit` is 0.
- R2: A `cmd_wr` strobe while idle is accepted. On the clock edge that samples it, `dir_out` takes bit 7 of `cmd_byte`: 1 means inward, away from track zero, and 0 means outward, toward track zero. If bits 6:0 are nonzero, `busy` is high from that same edge.
- R3: An accepted command that is not cut short by track zero issues exactly as many step pulses as bits 6:0 give, at most one per rising edge of `step_tick`, and then drops `busy`.
- R4: Every step pulse holds `step_n` low for exactly `PULSE_CYCLES` system clocks and then returns it high.
- R5: `dir_out` does not change while `busy` is high.
- R6: A command whose bits 6:0 are zero completes at once. `busy` never rises and no pulse is issued.
- R7: A `cmd_wr` strobe while `busy` is high is ignored. The direction and the remaining pulse count of the running seek are unchanged.
- R8: On an outward seek, if `trk0_in` is 1 while the block waits for the next step, the block issues no further pulse, drops `busy` on the next clock and sets `trk0_hit`. This holds even if steps remain, and even if track zero is already reported when the seek starts.
- R9: `trk0_hit` stays set until the next accepted command clears it. `trk0_hit` and `busy` are never high together.
- R10: `step_n` is low only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| step_tick | input | 1 | Step-rate clock level; each rising edge allows one step |
| cmd_byte | input | CMD_W | Command: MSB is direction, low bits are step count |
| cmd_wr | input | 1 | One-clock strobe that writes `cmd_byte` |
| trk0_in | input | 1 | 1 when the head is at track zero |
| step_n | output | 1 | Step pulse to the drive, active low |
| dir_out | output | 1 | Head direction, 1 = inward |
| busy | output | 1 | High while a seek is in progress |
| trk0_hit | output | 1 | Sticky: track zero was reached during an outward seek |

## Verification
`busy` and `dir_out` are due on the first clock edge after the strobe. The bench reads them at the falling edge that follows, so it samples the registered values.

The time at which each pulse starts depends on the free-running step clock. For that reason the bench does not predict absolute pulse times. Instead it samples `step_n` at every falling edge while `busy` is high. It counts falling transitions, measures each low run against `PULSE_CYCLES`, and confirms that `dir_out` holds.

After `busy` falls, the bench compares the pulse count and `trk0_hit` with the values its head-position model predicts. It then watches several more cycles to confirm that no stray pulse follows.

// File: rtl/hss_pkg.sv
package hss_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WAIT  = 2'd1,
      ST_PULSE = 2'd2
   } seq_state_t;
endpackage

// File: rtl/hss_rise_detect.sv
module hss_rise_detect (
   input  logic clk,
   input  logic rst,
   input  logic lvl,
   output logic rise
);
   logic lvl_q;

   always_ff @(posedge clk) begin
      if (rst) lvl_q <= 1'b0;
      else     lvl_q <= lvl;
   end

   assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/hss_pulse_timer.sv
module hss_pulse_timer #(
   parameter int PULSE_CYCLES = 100
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic active,
   output logic done
);
   localparam int CW = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;

   initial begin
      if (PULSE_CYCLES < 1)
         $error("hss_pulse_timer: PULSE_CYCLES must be at least 1");
   end

   generate
      if (PULSE_CYCLES == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (rst) active <= 1'b0;
            else     active <= start;
         end
         assign done = active;
      end else begin : g_count
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (rst) begin
               active <= 1'b0;
               cnt    <= '0;
            end else if (start) begin
               active <= 1'b1;
               cnt    <= CW'(PULSE_CYCLES - 1);
            end else if (active) begin
               if (cnt == '0) active <= 1'b0;
               else           cnt    <= cnt - 1'b1;
            end
         end
         assign done = active && (cnt == '0);
      end
   endgenerate

   // R4: a new pulse is never requested while one is still running
   p_no_restart_r4: assert property (@(posedge clk) disable iff (rst)
      start |-> !active);
endmodule

// File: rtl/head_step_seq.sv
module head_step_seq #(
   parameter int CMD_W        = 8,
   parameter int PULSE_CYCLES = 100
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step_tick,
   input  logic [CMD_W-1:0] cmd_byte,
   input  logic             cmd_wr,
   input  logic             trk0_in,
   output logic             step_n,
   output logic             dir_out,
   output logic             busy,
   output logic             trk0_hit
);
   import hss_pkg::*;

   localparam int CNT_W = CMD_W - 1;

   initial begin
      if (CMD_W < 2)
         $error("head_step_seq: CMD_W must be at least 2");
      if (PULSE_CYCLES < 1)
         $error("head_step_seq: PULSE_CYCLES must be at least 1");
   end

   seq_state_t       state;
   logic [CNT_W-1:0] remaining;
   logic             tick_rise;
   logic             pulse_active;
   logic             pulse_done;
   logic             at_zero_out;
   logic             fire;

   hss_rise_detect u_rise (
      .clk  (clk),
      .rst  (rst),
      .lvl  (step_tick),
      .rise (tick_rise)
   );

   assign at_zero_out = !dir_out && trk0_in;
   assign fire = (state == ST_WAIT) && !at_zero_out
               && (remaining != '0) && tick_rise;

   hss_pulse_timer #(.PULSE_CYCLES(PULSE_CYCLES)) u_timer (
      .clk    (clk),
      .rst    (rst),
      .start  (fire),
      .active (pulse_active),
      .done   (pulse_done)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= ST_IDLE;
         dir_out   <= 1'b0;
         remaining <= '0;
         trk0_hit  <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (cmd_wr) begin
                  dir_out   <= cmd_byte[CMD_W-1];
                  remaining <= cmd_byte[CNT_W-1:0];
                  trk0_hit  <= 1'b0;
                  if (cmd_byte[CNT_W-1:0] != '0) state <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (at_zero_out) begin
                  trk0_hit <= 1'b1;
                  state    <= ST_IDLE;
               end else if (remaining == '0) begin
                  state <= ST_IDLE;
               end else if (fire) begin
                  remaining <= remaining - 1'b1;
                  state     <= ST_PULSE;
               end
            end
            ST_PULSE: begin
               if (pulse_done) state <= ST_WAIT;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy   = (state != ST_IDLE);
   assign step_n = ~pulse_active;

   // R10: the step line only goes low inside a seek
   p_step_in_seek_r10: assert property (@(posedge clk) disable iff (rst)
      !step_n |-> busy);
   // R5: direction is held for the whole seek
   p_dir_hold_r5: assert property (@(posedge clk) disable iff (rst)
      (busy && $past(busy)) |-> $stable(dir_out));
   // R9: the sticky flag and busy never overlap
   p_hit_idle_r9: assert property (@(posedge clk) disable iff (rst)
      busy |-> !trk0_hit);
   // R6: a zero-count command never raises busy
   p_zero_cmd_r6: assert property (@(posedge clk) disable iff (rst)
      (!busy && cmd_wr && cmd_byte[CNT_W-1:0] == '0) |=> !busy);
   // R8: track zero while waiting on an outward seek ends it
   p_trk0_stop_r8: assert property (@(posedge clk) disable iff (rst)
      (state == ST_WAIT && !dir_out && trk0_in) |=> (!busy && trk0_hit));
   // R7: a write during a seek leaves the remaining count alone
   p_ignore_busy_r7: assert property (@(posedge clk) disable iff (rst)
      (state == ST_PULSE && cmd_wr) |=> (remaining == $past(remaining)));
endmodule

// File: tb/tb_head_step_seq.sv
module tb_head_step_seq;
   localparam int P    = 4;
   localparam int HALF = 16;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       step_tick = 1'b0;
   logic [7:0] cmd_byte = 8'h00;
   logic       cmd_wr = 1'b0;
   logic       trk0_in;
   logic       step_n, dir_out, busy, trk0_hit;

   int nchk = 0;
   int nfail = 0;
   int pos = 0;
   int tick_cnt = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;

   assign trk0_in = (pos == 0);

   head_step_seq #(.CMD_W(8), .PULSE_CYCLES(P)) dut (
      .clk(clk), .rst(rst), .step_tick(step_tick), .cmd_byte(cmd_byte),
      .cmd_wr(cmd_wr), .trk0_in(trk0_in), .step_n(step_n),
      .dir_out(dir_out), .busy(busy), .trk0_hit(trk0_hit)
   );

   always @(negedge clk) begin
      if (tick_cnt == HALF - 1) begin
         tick_cnt  <= 0;
         step_tick <= ~step_tick;
      end else begin
         tick_cnt <= tick_cnt + 1;
      end
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 190000) begin
         nfail++;
         $display("FAIL watchdog expired actual=%0d expected=<190000", cyc);
         $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_pulses(input logic [7:0] c, input int p);
      int n = int'(c[6:0]);
      if (c[7]) return n;
      return (n < p) ? n : p;
   endfunction

   function automatic bit exp_hit(input logic [7:0] c, input int p);
      return !c[7] && (c[6:0] != 0) && (p <= int'(c[6:0]));
   endfunction

   task automatic run_cmd(input logic [7:0] c, input int inj, input logic [7:0] inj_byte);
      int  ep     = exp_pulses(c, pos);
      bit  eh     = exp_hit(c, pos);
      int  pulses = 0;
      int  width  = 0;
      int  n      = 0;
      bit  prev;
      bit  extra;
      @(negedge clk);
      cmd_byte = c;
      cmd_wr   = 1'b1;
      @(negedge clk);
      cmd_wr = 1'b0;
      chk(busy == (c[6:0] != 0), (c[6:0] == 0) ? "R6 busy" : "R2 busy", busy, c[6:0] != 0);
      chk(dir_out == c[7], "R2 dir", dir_out, c[7]);
      chk(trk0_hit == 1'b0, "R9 hit cleared on accept", trk0_hit, 0);
      prev = step_n;
      while ((busy || !step_n) && n < 20000) begin
         @(negedge clk);
         n++;
         if (inj != 0 && n == inj) begin
            cmd_byte = inj_byte;
            cmd_wr   = 1'b1;
         end else if (inj != 0 && n == inj + 1) begin
            cmd_wr = 1'b0;
         end
         if (prev && !step_n) begin
            pulses++;
            width = 1;
            if (dir_out) pos++;
            else if (pos > 0) pos--;
         end else if (!step_n) begin
            width++;
         end
         if (!prev && step_n)
            chk(width == P, "R4 pulse width", width, P);
         if (busy && dir_out != c[7])
            chk(0, "R5/R7 dir held", dir_out, c[7]);
         if (!step_n && !busy)
            chk(0, "R10 step outside busy", busy, 1);
         prev = step_n;
      end
      chk(pulses == ep, c[7] ? "R3 pulse count" : "R8 pulse count", pulses, ep);
      chk(trk0_hit == eh, "R8 hit flag", trk0_hit, eh);
      extra = 0;
      for (int k = 0; k < 3 * HALF; k++) begin
         @(negedge clk);
         if (!step_n || busy) extra = 1;
      end
      chk(!extra, "R3/R8 no step after end", extra, 0);
      chk(trk0_hit == eh, "R9 hit sticky", trk0_hit, eh);
   endtask

   initial begin
      logic [7:0] c;
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(step_n == 1'b1, "R1 step_n", step_n, 1);
      chk(busy == 1'b0, "R1 busy", busy, 0);
      chk(trk0_hit == 1'b0, "R1 hit", trk0_hit, 0);

      pos = 0;
      run_cmd(8'h85, 0, 8'h00);
      chk(pos == 5, "R3 head position", pos, 5);
      run_cmd(8'h0A, 0, 8'h00);
      run_cmd(8'h03, 0, 8'h00);
      run_cmd(8'h00, 0, 8'h00);
      run_cmd(8'h83, 0, 8'h00);
      run_cmd(8'h02, 0, 8'h00);
      pos = 4;
      run_cmd(8'h83, 3, 8'h05);
      chk(pos == 7, "R7 ignored write", pos, 7);
      run_cmd(8'h80, 0, 8'h00);
      run_cmd(8'hFF, 0, 8'h00);
      chk(pos == 134, "R3 full count", pos, 134);
      run_cmd(8'h01, 0, 8'h00);

      for (int i = 0; i < 30; i++) begin
         pos = $urandom_range(0, 10);
         c[7]   = 1'($urandom_range(0, 1));
         c[6:0] = 7'($urandom_range(0, 14));
         run_cmd(c, ($urandom_range(0, 3) == 0) ? 2 : 0, 8'($urandom));
      end

      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule